// File: doc/BRIEF.md
# Instruction Fetch and Next-PC Unit

This block owns the program counter of a single-cycle processor and decides, once per clock, where the next instruction comes from. It reads the current instruction from a word-organized instruction store that is filled with a fixed, computed test image. It returns that instruction and the current PC to the rest of the datapath. From the control unit it takes a branch-select bit and a jump bit. From the ALU it takes the zero flag.

Three candidate addresses are formed every cycle: the sequential address, the branch target and the jump target. A branch is taken only when the branch-select bit and the zero flag are both high. The jump bit then overrides whatever the branch stage chose. The jump target keeps the top four bits of the current PC and takes the rest from the instruction's 26-bit target field. The register file, the ALU, prediction and delay slots belong to other blocks.

Top module: `ifu_fetch_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, `pc` becomes 0x00000000 after that edge. Reset is synchronous and active low.
- R2: When `jmp_en` is low and the branch is not taken, `pc` becomes `pc + 4` at the next rising edge.
- R3: When `br_sel` and `alu_zero` are both high and `jmp_en` is low, `pc` becomes `pc + 4 + (sign-extended instr[15:0] << 2)` at the next rising edge. The sum wraps modulo 2^32.
- R4: `br_sel` high with `alu_zero` low, or `alu_zero` high with `br_sel` low, gives the sequential address `pc + 4`.
- R5: When `jmp_en` is high, `pc` becomes `{pc[31:28], instr[25:0], 2'b00}` at the next rising edge. The top four bits come from the current PC.
- R6: When `jmp_en` is high while a branch would also be taken, the jump target of R5 wins.
- R7: `instr` is a combinational function of the current `pc`. It shows the store word at index `pc[IMEM_ADDR_W+1:2]`, so addresses wrap modulo the store depth. `pc` changes only at rising edges.
- R8: The store word at index i equals `(i * 32'h9E3779B1 + 32'h01234567) mod 2^32`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| br_sel | input | 1 | Branch-select control from the decoder |
| jmp_en | input | 1 | Jump control from the decoder |
| alu_zero | input | 1 | Zero flag from the ALU |
| instr | output | 32 | Instruction fetched at the current PC |
| pc | output | 32 | Current program counter |

## Verification
The hardest case to reach from the ports is a jump taken while the upper four PC bits are non-zero. The PC starts at zero, and jump targets alone never leave the low 256 MB. To get there, the bench steps sequentially from reset until the fetched word holds a negative offset larger than the current address. It then takes that branch, which wraps the PC below zero into the top nibble 0xF. A jump issued at that point shows whether the upper bits are kept. A jump that coincides with a taken branch and a reset in mid-run follow, after a long stretch of random control patterns checked against a behavioural model.

// File: rtl/ifu_pkg.sv
// Shared types and the computed test image for the fetch unit.
// Assumes a 32-bit word and byte addressing with 4-byte instructions.
package ifu_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned IMM_W    = 16;
    localparam int unsigned TGT_W    = 26;
    localparam int unsigned SEG_W    = 4;

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t IMAGE_MUL  = 32'h9E37_79B1;
    localparam word_t IMAGE_BASE = 32'h0123_4567;

    // Test image word at a given store index (wraps modulo 2^32).
    function automatic word_t image_word(input int unsigned idx);
        return word_t'(idx) * IMAGE_MUL + IMAGE_BASE;
    endfunction
endpackage

// File: rtl/ifu_imem.sv
// Read-only instruction store holding the computed test image.
// Assumes a power-of-two depth; the read is purely combinational.
module ifu_imem
    import ifu_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] word_idx,
    output word_t             rd_word
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    word_t rom [DEPTH];

    // One constant word per entry, computed from its index.
    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom[g] = image_word(g);
    end

    // Combinational read of the addressed word.
    assign rd_word = rom[word_idx];
endmodule

// File: rtl/ifu_next_pc.sv
// Next-PC selection: sequential, branch-taken and pseudo-direct jump.
// Assumes the branch is qualified by the zero flag and that a jump
// overrides the branch/sequential choice.
module ifu_next_pc
    import ifu_pkg::*;
(
    input  word_t              cur_pc,
    input  logic [TGT_W-1:0]   tgt_field,
    input  logic               br_sel,
    input  logic               jmp_en,
    input  logic               alu_zero,
    output word_t              nxt_pc
);
    localparam int unsigned EXT_W = WORD_W - IMM_W - 2;

    word_t seq_pc;
    word_t br_off;
    word_t br_pc;
    word_t jmp_pc;
    word_t stage1_pc;
    logic  br_take;

    // Candidate addresses and the two-level selection.
    always_comb begin
        seq_pc    = cur_pc + word_t'(4);
        br_off    = {{EXT_W{tgt_field[IMM_W-1]}}, tgt_field[IMM_W-1:0], 2'b00};
        br_pc     = seq_pc + br_off;
        jmp_pc    = {cur_pc[WORD_W-1 -: SEG_W], tgt_field, 2'b00};
        br_take   = br_sel & alu_zero;
        stage1_pc = br_take ? br_pc : seq_pc;
        nxt_pc    = jmp_en ? jmp_pc : stage1_pc;
    end
endmodule

// File: rtl/ifu_pc_reg.sv
// Program counter register with synchronous active-low reset.
// Assumes the reset vector is a parameter constant.
module ifu_pc_reg
    import ifu_pkg::*;
#(
    parameter word_t RESET_PC = '0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  word_t d_pc,
    output word_t q_pc
);
    // Load the reset vector or the selected next address.
    always_ff @(posedge clk) begin
        if (!rst_n) q_pc <= RESET_PC;
        else        q_pc <= d_pc;
    end
endmodule

// File: rtl/ifu_fetch_unit.sv
// Top of the fetch unit: PC register, next-PC logic and instruction store.
// Assumes single-cycle operation: one fetch and one PC update per clock.
module ifu_fetch_unit
    import ifu_pkg::*;
#(
    parameter int unsigned IMEM_ADDR_W = 6,
    parameter word_t       RESET_PC    = '0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        br_sel,
    input  logic        jmp_en,
    input  logic        alu_zero,
    output logic [31:0] instr,
    output logic [31:0] pc
);
    word_t nxt_pc;

    ifu_pc_reg #(.RESET_PC(RESET_PC)) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .d_pc  (nxt_pc),
        .q_pc  (pc)
    );

    ifu_imem #(.ADDR_W(IMEM_ADDR_W)) u_imem (
        .word_idx (pc[IMEM_ADDR_W+1:2]),
        .rd_word  (instr)
    );

    ifu_next_pc u_npc (
        .cur_pc    (pc),
        .tgt_field (instr[TGT_W-1:0]),
        .br_sel    (br_sel),
        .jmp_en    (jmp_en),
        .alu_zero  (alu_zero),
        .nxt_pc    (nxt_pc)
    );
endmodule

// File: rtl/ifu_fetch_checker.sv
// Temporal checks on the fetch unit's ports, bound into every instance.
// Assumes only the low 26 instruction bits matter for address formation.
module ifu_fetch_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        br_sel,
    input logic        jmp_en,
    input logic        alu_zero,
    input logic [25:0] fld,
    input logic [31:0] pc
);
    logic primed = 1'b0;
    logic rst_q  = 1'b1;

    // Remember whether the previous edge applied reset.
    always_ff @(posedge clk) begin
        primed <= 1'b1;
        rst_q  <= rst_n;
    end

    // R1: the edge after a reset edge must show a zero PC.
    always_ff @(posedge clk) begin
        if (primed && !rst_q) begin
            a_r1_reset_zero: assert (pc == 32'h0)
                else $error("a_r1_reset_zero pc=%h", pc);
        end
    end

    a_r2_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        (!jmp_en && !br_sel && !alu_zero) |=> pc == $past(pc) + 32'd4);

    a_r3_branch_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (br_sel && alu_zero && !jmp_en) |=>
        pc == $past(pc) + 32'd4 + {{14{$past(fld[15])}}, $past(fld[15:0]), 2'b00});

    a_r4_half_condition: assert property (@(posedge clk) disable iff (!rst_n)
        (!jmp_en && (br_sel != alu_zero)) |=> pc == $past(pc) + 32'd4);

    a_r5_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_en |=> pc == {$past(pc[31:28]), $past(fld), 2'b00});

    a_r6_jump_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_en && br_sel && alu_zero) |=> pc[27:2] == $past(fld));
endmodule

bind ifu_fetch_unit ifu_fetch_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .br_sel   (br_sel),
    .jmp_en   (jmp_en),
    .alu_zero (alu_zero),
    .fld      (instr[25:0]),
    .pc       (pc)
);

// File: tb/tb_ifu_fetch_unit.sv
`timescale 1ns/1ps
// Behavioural reference bench for the fetch unit, compared every cycle.
module tb_ifu_fetch_unit;
    localparam int ADDR_W = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_sel = 1'b0;
    logic        jmp_en = 1'b0;
    logic        alu_zero = 1'b0;
    logic [31:0] instr;
    logic [31:0] pc;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] exp_pc = 32'h0;

    ifu_fetch_unit #(.IMEM_ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .br_sel(br_sel), .jmp_en(jmp_en),
        .alu_zero(alu_zero), .instr(instr), .pc(pc)
    );

    always #10 clk = ~clk;

    // Expected store contents (R8): index times a constant plus an offset.
    function automatic logic [31:0] model_word(input logic [31:0] addr);
        longint unsigned idx = longint'((addr >> 2) % (1 << ADDR_W));
        longint unsigned v   = idx * 64'h9E3779B1 + 64'h01234567;
        return v[31:0];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: an overlong run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            finish_run();
        end
    end

    // One clock with the given controls; model the next PC and compare.
    task automatic step(input logic b, input logic j, input logic z);
        logic [31:0] w;
        longint signed off;
        string tag;
        w = model_word(exp_pc);
        br_sel = b; jmp_en = j; alu_zero = z;
        if (j) begin
            exp_pc = {exp_pc[31:28], w[25:0], 2'b00};
            tag = (b && z) ? "R6" : "R5";
        end else if (b && z) begin
            off = longint'($signed(w[15:0])) * 4;
            exp_pc = 32'(longint'(exp_pc) + 4 + off);
            tag = "R3";
        end else begin
            exp_pc = exp_pc + 32'd4;
            tag = (b || z) ? "R4" : "R2";
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, pc, exp_pc);
        check("R7", instr, model_word(exp_pc));
    endtask

    task automatic do_reset(input int n);
        rst_n = 1'b0; br_sel = 1'b0; jmp_en = 1'b0; alu_zero = 1'b0;
        repeat (n) @(posedge clk);
        @(negedge clk);
        exp_pc = 32'h0;
        check("R1", pc, 32'h0);
        check("R8", instr, 32'h01234567);
        rst_n = 1'b1;
    endtask

    initial begin
        bit found;
        @(negedge clk);
        do_reset(2);

        // Random control patterns against the model (R2..R7).
        for (int i = 0; i < 600; i++) begin
            logic [2:0] r;
            r = 3'($urandom);
            step(r[0], (r == 3'b111) ? 1'b1 : 1'b0, r[1]);
        end
        // Directed half conditions (R4) and plain sequencing (R2).
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b0);

        // Wrap below zero into the top segment, then jump there (R3, R5).
        @(negedge clk);
        do_reset(1);
        found = 1'b0;
        for (int i = 0; i < 300 && !found; i++) begin
            logic [31:0] w;
            w = model_word(exp_pc);
            if (w[15] && (longint'(exp_pc) + 4 + longint'($signed(w[15:0])) * 4 < 0)) begin
                step(1'b1, 1'b0, 1'b1);
                found = 1'b1;
            end else begin
                step(1'b0, 1'b0, 1'b0);
            end
        end
        check("R3 wrap", {28'h0, pc[31:28]}, 32'hF);
        step(1'b0, 1'b1, 1'b0);
        check("R5 upper", {28'h0, pc[31:28]}, 32'hF);
        // Jump together with a taken branch (R6).
        step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b1);

        // Reset applied in mid-run (R1).
        @(negedge clk);
        do_reset(1);
        step(1'b0, 1'b0, 1'b0);
        check("R7 idx1", instr, model_word(32'h4));

        finish_run();
    end
endmodule